// File: doc/BRIEF.md
# Sector Lock-Register Controller for a Serial NOR Flash

This block is the command-side logic of a serial NOR flash that handles two commands from an SPI mode 0 host. The first is write enable. The second writes one sector's volatile lock register. Chip select, serial clock and serial data are sampled by the device's system clock through a synchronizer. Bits are taken on rising serial-clock edges, MSB first.

The block keeps one lock register for each sector. Each register holds a write-lock bit and a lock-down bit, and both are driven out to the program/erase logic. The block also keeps the write enable latch, WEL.

A lock write takes effect only when all of these hold:
- WEL was already set.
- Chip select rises exactly after the 40th bit.
- The external busy flag is low.
- The target sector is not locked down.

Top module: `lockreg_ctrl`

## Requirements
- R1: After reset, WEL and every sector's write-lock and lock-down bits are 0.
- R2: A frame with opcode 0x06 that ends with chip select rising after exactly 8 bits sets WEL. The same opcode ending after any other bit count leaves WEL unchanged.
- R3: A frame with opcode 0xE5, a 24-bit address and a data byte (40 bits, MSB first) updates the addressed sector when WEL is set. Data bit 0 becomes the write-lock bit and data bit 1 becomes the lock-down bit. Data bits 7..2 are ignored. WEL then clears.
- R4: A 0xE5 frame sent while WEL is 0 changes no lock bit.
- R5: A 0xE5 frame that ends after any bit count other than 40 changes no lock bit and leaves WEL as it was.
- R6: A 0xE5 frame whose chip-select release comes while busy_i is high changes no lock bit and leaves WEL set.
- R7: Once a sector's lock-down bit is 1, later writes to that sector change neither of its bits and leave WEL set, until reset.
- R8: Frames with any other opcode change neither WEL nor any lock bit.
- R9: Address bits 20..16 select the sector (0..31). All other address bits have no effect on which register is written.
- R10: The bit counter restarts at every chip-select fall, so a valid command after an aborted frame is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_sclk_i | input | 1 | SPI serial clock, mode 0 |
| spi_mosi_i | input | 1 | SPI serial data in |
| busy_i | input | 1 | Program/erase cycle in progress |
| wel_o | output | 1 | Write enable latch |
| wlock_o | output | 32 | Per-sector write-lock bits |
| ldown_o | output | 32 | Per-sector lock-down bits |

## Verification
The bench releases chip select at off-by-one points: after 39 and 41 bits on a lock write, and after 9 bits on write enable. A design that compared lengths loosely or let the counter wrap would then commit a frame that should have been dropped. It sends lock writes with WEL clear and with busy high. A wrong design would change lock bits there, or drop WEL on a command that was rejected. It also writes a locked-down sector again, and uses addresses with noisy low bits at sectors 0, 3 and 31. These catch lock-down that is not sticky, a sector index taken from the wrong address bits, and data bits 7..2 leaking into the register. Last, it sends an aborted 12-bit frame just before a write enable, which exposes a counter that fails to restart on the chip-select fall.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_WRLR    = 8'hE5;
  localparam int         OP_BITS    = 8;
  localparam int         ADDR_BITS  = 24;
  localparam int         DATA_BITS  = 8;
  localparam int         FRAME_BITS = OP_BITS + ADDR_BITS + DATA_BITS;
  localparam int         PAY_BITS   = ADDR_BITS + DATA_BITS;
  localparam int         CNT_W      = $clog2(FRAME_BITS + 2) + 1;
endpackage

// File: rtl/lockreg_sampler.sv
module lockreg_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_low_o,
  output logic sclk_rise_o,
  output logic mosi_o
);
  // stage k: {cs_n, sclk, mosi}
  logic [SYNC_STAGES:0][2:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= SYNC_STAGES; k++) pipe_q[k] <= 3'b100;
    end else begin
      pipe_q[0] <= {cs_ni, sclk_i, mosi_i};
      for (int k = 1; k <= SYNC_STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  localparam int CUR = SYNC_STAGES - 1;
  localparam int OLD = SYNC_STAGES;

  assign cs_low_o    = ~pipe_q[CUR][2];
  assign cs_fall_o   = ~pipe_q[CUR][2] &  pipe_q[OLD][2];
  assign cs_rise_o   =  pipe_q[CUR][2] & ~pipe_q[OLD][2];
  assign sclk_rise_o =  pipe_q[CUR][1] & ~pipe_q[OLD][1] & ~pipe_q[CUR][2];
  assign mosi_o      =  pipe_q[CUR][0];
endmodule

// File: rtl/lockreg_shifter.sv
module lockreg_shifter
  import lockreg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_fall_i,
  input  logic                sclk_rise_i,
  input  logic                mosi_i,
  output logic [OP_BITS-1:0]  opcode_o,
  output logic [PAY_BITS-1:0] payload_o,
  output logic [CNT_W-1:0]    bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [OP_BITS-1:0]  op_q;
  logic [PAY_BITS-1:0] pay_q;
  logic [CNT_W-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      pay_q <= '0;
      cnt_q <= '0;
    end else if (cs_fall_i) begin
      cnt_q <= '0;
    end else if (sclk_rise_i) begin
      if (cnt_q < CNT_W'(OP_BITS)) op_q  <= {op_q[OP_BITS-2:0], mosi_i};
      else                         pay_q <= {pay_q[PAY_BITS-2:0], mosi_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;  // saturate, never wrap to a valid length
    end
  end

  assign opcode_o  = op_q;
  assign payload_o = pay_q;
  assign bit_cnt_o = cnt_q;

  a_r10_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (bit_cnt_o == '0));
endmodule

// File: rtl/lockreg_bank.sv
module lockreg_bank #(
  parameter int NUM_SECT = 32,
  localparam int SECT_W = $clog2(NUM_SECT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [SECT_W-1:0]   sect_i,
  input  logic                wlock_i,
  input  logic                ldown_i,
  output logic [NUM_SECT-1:0] wlock_o,
  output logic [NUM_SECT-1:0] ldown_o
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic wl_q, ld_q;
    logic hit;
    assign hit = wr_i && (sect_i == SECT_W'(s)) && !ld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wl_q <= 1'b0;
        ld_q <= 1'b0;
      end else if (hit) begin
        wl_q <= wlock_i;
        ld_q <= ldown_i;
      end
    end

    assign wlock_o[s] = wl_q;
    assign ldown_o[s] = ld_q;

    a_r7_ldown_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ldown_o[s] |=> (ldown_o[s] && $stable(wlock_o[s])));
    a_r9_only_addressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && sect_i != SECT_W'(s)) |=> ($stable(wlock_o[s]) && $stable(ldown_o[s])));
  end
endmodule

// File: rtl/lockreg_ctrl.sv
module lockreg_ctrl
  import lockreg_pkg::*;
#(
  parameter int NUM_SECT      = 32,
  parameter int SECT_ADDR_LSB = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                spi_cs_ni,
  input  logic                spi_sclk_i,
  input  logic                spi_mosi_i,
  input  logic                busy_i,
  output logic                wel_o,
  output logic [NUM_SECT-1:0] wlock_o,
  output logic [NUM_SECT-1:0] ldown_o
);
  localparam int SECT_W = $clog2(NUM_SECT);

  logic cs_fall, cs_rise, cs_low, sclk_rise, mosi_s;
  logic [OP_BITS-1:0]   opcode;
  logic [PAY_BITS-1:0]  payload;
  logic [CNT_W-1:0]     bit_cnt;
  logic [ADDR_BITS-1:0] addr;
  logic [DATA_BITS-1:0] data;
  logic [SECT_W-1:0]    sect;
  logic                 wel_q, wren_ok, wrlr_ok;

  lockreg_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk_i, .rst_ni,
    .cs_ni(spi_cs_ni), .sclk_i(spi_sclk_i), .mosi_i(spi_mosi_i),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .cs_low_o(cs_low),
    .sclk_rise_o(sclk_rise), .mosi_o(mosi_s)
  );

  lockreg_shifter u_shift (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .sclk_rise_i(sclk_rise), .mosi_i(mosi_s),
    .opcode_o(opcode), .payload_o(payload), .bit_cnt_o(bit_cnt)
  );

  assign addr = payload[PAY_BITS-1 -: ADDR_BITS];
  assign data = payload[DATA_BITS-1:0];
  assign sect = addr[SECT_ADDR_LSB +: SECT_W];

  assign wren_ok = cs_rise && (bit_cnt == CNT_W'(OP_BITS))    && (opcode == OP_WREN);
  assign wrlr_ok = cs_rise && (bit_cnt == CNT_W'(FRAME_BITS)) && (opcode == OP_WRLR)
                && wel_q && !busy_i && !ldown_o[sect];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wel_q <= 1'b0;
    else if (wrlr_ok) wel_q <= 1'b0;
    else if (wren_ok) wel_q <= 1'b1;
  end

  lockreg_bank #(.NUM_SECT(NUM_SECT)) u_bank (
    .clk_i, .rst_ni,
    .wr_i(wrlr_ok), .sect_i(sect),
    .wlock_i(data[0]), .ldown_i(data[1]),
    .wlock_o, .ldown_o
  );

  assign wel_o = wel_q;

  a_r3_wel_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrlr_ok |=> !wel_o);
  a_r4_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wel_o) |-> ($stable(wlock_o) && $stable(ldown_o)));
  a_r6_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> ($stable(wlock_o) && $stable(ldown_o)));
  a_r2_wel_only_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise |=> $stable(wel_o));
endmodule

// File: tb/tb_lockreg_ctrl.sv
module tb_lockreg_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic wel;
  logic [31:0] wlock, ldown;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic        m_wel = 1'b0;
  logic [31:0] m_wl = '0, m_ld = '0;

  always #4 clk = ~clk;

  lockreg_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .spi_cs_ni(cs_n), .spi_sclk_i(sclk),
    .spi_mosi_i(mosi), .busy_i(busy), .wel_o(wel), .wlock_o(wlock), .ldown_o(ldown)
  );

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, {wel, wlock, ldown}, {m_wel, m_wl, m_ld});
  endtask

  // compare against the model on every clock while outputs are settled
  always @(negedge clk) if (cmp_en && rst_n && !done) check_state(cur_req);

  function automatic void model_commit(input logic [39:0] v, input int n, input logic bsy);
    logic [7:0] op;
    logic [4:0] s;
    op = v[39:32];
    s  = v[28:24];  // address bits 20..16
    if (n == 8 && op == 8'h06) m_wel = 1'b1;
    else if (n == 40 && op == 8'hE5 && m_wel && !bsy && !m_ld[s]) begin
      m_wl[s] = v[0];
      m_ld[s] = v[1];
      m_wel   = 1'b0;
    end
  endfunction

  task automatic frame(input logic [39:0] v, input int n, input logic bsy);
    @(negedge clk);
    cmp_en = 1'b0;
    busy = bsy;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = v[39-i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    model_commit(v, n, bsy);
    repeat (8) @(negedge clk);
    busy = 1'b0;
    cmp_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [39:0] wrlr(input logic [23:0] a, input logic [7:0] d);
    return {8'hE5, a, d};
  endfunction

  localparam logic [39:0] WREN = {8'h06, 32'h0};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 reset state");
    cmp_en = 1'b1;

    cur_req = "R4"; frame(wrlr(24'h03_0000, 8'h01), 40, 1'b0);
    check_state("R4 write without WEL");

    cur_req = "R2"; frame(WREN, 9, 1'b0);
    check_state("R2 wren 9 bits");
    frame(WREN, 8, 1'b0);
    check("R2 wren sets WEL", wel, 1'b1);

    cur_req = "R3"; frame(wrlr(24'h03_ABCD, 8'hFD), 40, 1'b0);
    check("R3 wlock sector 3", wlock[3], 1'b1);
    check("R3 WEL cleared", wel, 1'b0);
    check_state("R3 upper data ignored");

    cur_req = "R5"; frame(WREN, 8, 1'b0);
    frame(wrlr(24'h07_0000, 8'h01), 39, 1'b0);
    check_state("R5 39 bits");
    frame(wrlr(24'h07_0000, 8'h01), 41, 1'b0);
    check("R5 41 bits keeps WEL", wel, 1'b1);
    check_state("R5 41 bits");

    cur_req = "R6"; frame(wrlr(24'h05_0000, 8'h03), 40, 1'b1);
    check("R6 busy keeps WEL", wel, 1'b1);
    check_state("R6 busy ignored");

    cur_req = "R8"; frame({8'hAB, 24'h05_0000, 8'h03}, 40, 1'b0);
    check_state("R8 unknown opcode 40 bits");
    frame({8'h04, 32'h0}, 8, 1'b0);
    check_state("R8 unknown opcode 8 bits");

    cur_req = "R9"; frame(wrlr(24'h1F_0001, 8'h02), 40, 1'b0);
    check("R9 sector 31 lock-down", ldown[31], 1'b1);
    check_state("R9 sector 31");

    cur_req = "R7"; frame(WREN, 8, 1'b0);
    frame(wrlr(24'h1F_8000, 8'h01), 40, 1'b0);
    check("R7 locked sector unchanged", {wlock[31], ldown[31]}, 2'b01);
    check("R7 WEL kept", wel, 1'b1);

    cur_req = "R9"; frame(wrlr(24'hE0_FFFF, 8'h03), 40, 1'b0);
    check("R9 sector 0 via high junk", {wlock[0], ldown[0]}, 2'b11);
    check_state("R9 sector 0");

    cur_req = "R10"; frame({8'h06, 32'hFFFF_FFFF}, 12, 1'b0);
    check_state("R10 aborted frame");
    frame(WREN, 8, 1'b0);
    check("R10 wren after abort", wel, 1'b1);
    frame(wrlr(24'h10_1234, 8'h01), 40, 1'b0);
    check("R10 write after abort", wlock[16], 1'b1);
    check_state("R10 final");

    cur_req = "R1"; rst_n = 1'b0; cmp_en = 1'b0;
    m_wel = 1'b0; m_wl = '0; m_ld = '0;
    repeat (2) @(negedge clk);
    check_state("R1 reset clears locks");
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule